// File: doc/BRIEF.md
# Digital Potentiometer Register Executor

This block takes one 16-bit command word at a time, decodes it and applies it to the register set of a four-channel digital potentiometer. The upper byte of the word is the instruction: a 3-bit operation code above a 5-bit register address. The lower byte is the data. The register set holds four live wiper positions and four stored power-up positions. It also holds eleven general-purpose stored bytes, a reserved location and a control register.

A mode bit in the control register decides which bank an address reaches. The address can reach either the live wiper or its stored twin. A write to a stored location raises a one-cycle request toward the non-volatile controller, and a write to a stored wiper position also moves the live wiper. While the controller reports busy, the block accepts only control register reads, so the host can poll the busy flag. The controller can also push recalled bytes into the stored registers. When a recalled byte is a wiper position, it lands in the live wiper as well.

Read responses come back one clock after the command as a word: the instruction byte echoed above the read data. The four wiper positions drive the analog switch array. A shutdown output and an output-type select bit go with them.

Top module: `potreg_exec`

## Requirements
- R1: Instruction bits [15:13] of cmd_word are the opcode and bits [12:8] the address. Opcode 001 reads and 011 writes the control register, ignoring the address bits. Opcode 100 reads and 110 writes the addressed register. Opcodes 000, 010, 101 and 111 change nothing and give no response. A read sets rsp_valid for one cycle, one clock after cmd_valid, with rsp_word[15:8] equal to the instruction.
- R2: After reset every wiper and stored wiper position is 80h, every general-purpose byte is 00h, and the control register reads 40h.
- R3: With the mode bit set, addresses 00h–03h read and write live wipers 0–3 only, and raise no write request.
- R4: With the mode bit clear, addresses 00h–03h reach the stored positions. A write also loads the live wiper and raises nvw_valid with that address and data. A read leaves the live wiper unchanged.
- R5: Addresses 04h–0Eh are general-purpose bytes. With the mode bit clear they can be read and written, and a write raises a request. With the mode bit set they read 00h and ignore writes.
- R6: Address 0Fh and addresses above 10h read 00h and ignore writes.
- R7: The control register reads as {mode, run, busy, 000, sdo_type, 0}. The mode bit is bit 7, run is bit 6, busy is bit 5 and follows nv_busy, and sdo_type is bit 1. It is reached by opcodes 001/011 and by address 10h. sdo_open_drain follows bit 1.
- R8: With the run bit at 0, shutdown is 1 and every wiper output reads 00h. Wiper registers keep their values and may still be written. Setting run to 1 brings the held positions back to the outputs.
- R9: While nv_busy is 1, only control register reads act. Every other command changes nothing and raises no request. A blocked read answers with its instruction and data 00h.
- R10: recall_valid loads recall_data into the register at recall_addr (00h–0Eh). For 00h–03h it also loads the live wiper. A command in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Execute strobe for cmd_word |
| cmd_word | input | 16 | Instruction byte above data byte |
| nv_busy | input | 1 | Non-volatile write in progress |
| recall_valid | input | 1 | Recalled byte present |
| recall_addr | input | 5 | Register address of recalled byte |
| recall_data | input | 8 | Recalled byte |
| wiper_out | output | 32 | Wiper positions, channel 0 in bits [7:0] |
| shutdown | output | 1 | All channels in shutdown |
| sdo_open_drain | output | 1 | Serial output type select |
| rsp_valid | output | 1 | Read response valid |
| rsp_word | output | 16 | Echoed instruction above read data |
| nvw_valid | output | 1 | Non-volatile write request |
| nvw_addr | output | 5 | Address of requested write |
| nvw_data | output | 8 | Data of requested write |

## Verification
A wiper register corrupted inside the block appears on wiper_out in the very next cycle, unless shutdown is masking it. In that case it appears in the cycle after the run bit returns. A wrong mode or run bit changes which value the next addressed read returns and whether a write request is raised, so it is exposed at the first command after the fault. A broken busy gate shows up as a moved wiper, a changed control readback or a stray write request one cycle after the offending command.

// File: rtl/potreg_pkg.sv
package potreg_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'b000,
        OP_CRD = 3'b001,
        OP_CWR = 3'b011,
        OP_ARD = 3'b100,
        OP_AWR = 3'b110
    } op_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_CHAN = 2'd1,
        K_GP   = 2'd2,
        K_CTRL = 2'd3
    } kind_e;

    localparam int MODE_BIT = 7;
    localparam int RUN_BIT  = 6;
    localparam int BUSY_BIT = 5;
    localparam int ODT_BIT  = 1;
endpackage

// File: rtl/potreg_decode.sv
module potreg_decode
    import potreg_pkg::*;
#(
    parameter int AW     = 5,
    parameter int NUM_CH = 4,
    parameter int NUM_GP = 11,
    localparam int IW    = 3 + AW
) (
    input  logic [IW-1:0] instr,
    input  logic          busy,
    output logic          is_rd,
    output logic          is_wr,
    output kind_e         kind,
    output logic [AW-1:0] addr,
    output logic          blocked
);
    localparam logic [AW-1:0] GP_END   = AW'(NUM_CH + NUM_GP);
    localparam logic [AW-1:0] CTRL_ADR = AW'(NUM_CH + NUM_GP + 1);

    logic [2:0] op;
    kind_e      addr_kind;

    assign op   = instr[IW-1:AW];
    assign addr = instr[AW-1:0];

    always_comb begin
        if (addr < AW'(NUM_CH))     addr_kind = K_CHAN;
        else if (addr < GP_END)     addr_kind = K_GP;
        else if (addr == CTRL_ADR)  addr_kind = K_CTRL;
        else                        addr_kind = K_NONE;
    end

    always_comb begin
        is_rd = 1'b0;
        is_wr = 1'b0;
        kind  = K_NONE;
        case (op)
            OP_CRD: begin is_rd = 1'b1; kind = K_CTRL;    end
            OP_CWR: begin is_wr = 1'b1; kind = K_CTRL;    end
            OP_ARD: begin is_rd = 1'b1; kind = addr_kind; end
            OP_AWR: begin is_wr = 1'b1; kind = addr_kind; end
            default: ;
        endcase
    end

    // only a control register read passes while the non-volatile side is busy
    assign blocked = busy && !(is_rd && kind == K_CTRL);
endmodule

// File: rtl/potreg_wiper_out.sv
module potreg_wiper_out #(
    parameter int NUM_CH = 4,
    parameter int DW     = 8
) (
    input  logic [NUM_CH-1:0][DW-1:0] pos,
    input  logic                      halt,
    output logic [NUM_CH*DW-1:0]      bus
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign bus[c*DW +: DW] = halt ? '0 : pos[c];
    end
endmodule

// File: rtl/potreg_exec.sv
module potreg_exec
    import potreg_pkg::*;
#(
    parameter int          AW        = 5,
    parameter int          DW        = 8,
    parameter int          NUM_CH    = 4,
    parameter int          NUM_GP    = 11,
    parameter logic [7:0]  RESET_POS = 8'h80,
    localparam int         IW        = 3 + AW,
    localparam int         RW        = IW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [RW-1:0]        cmd_word,
    input  logic                 nv_busy,
    input  logic                 recall_valid,
    input  logic [AW-1:0]        recall_addr,
    input  logic [DW-1:0]        recall_data,
    output logic [NUM_CH*DW-1:0] wiper_out,
    output logic                 shutdown,
    output logic                 sdo_open_drain,
    output logic                 rsp_valid,
    output logic [RW-1:0]        rsp_word,
    output logic                 nvw_valid,
    output logic [AW-1:0]        nvw_addr,
    output logic [DW-1:0]        nvw_data
);
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int GW = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;
    localparam logic [AW-1:0] GP_END = AW'(NUM_CH + NUM_GP);

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] wiper;
        logic [NUM_CH-1:0][DW-1:0] stored;
        logic [NUM_GP-1:0][DW-1:0] gp;
        logic                      mode;
        logic                      run;
        logic                      odt;
        logic                      rsp_v;
        logic [RW-1:0]             rsp_w;
        logic                      nvw_v;
        logic [AW-1:0]             nvw_a;
        logic [DW-1:0]             nvw_d;
    } state_t;

    state_t st_d, st_q;

    logic          dec_rd, dec_wr, dec_blk;
    kind_e         dec_kind;
    logic [AW-1:0] dec_addr;
    logic [IW-1:0] instr;
    logic [DW-1:0] wdata;

    assign instr = cmd_word[RW-1:DW];
    assign wdata = cmd_word[DW-1:0];

    potreg_decode #(.AW(AW), .NUM_CH(NUM_CH), .NUM_GP(NUM_GP)) u_dec (
        .instr   (instr),
        .busy    (nv_busy),
        .is_rd   (dec_rd),
        .is_wr   (dec_wr),
        .kind    (dec_kind),
        .addr    (dec_addr),
        .blocked (dec_blk)
    );

    potreg_wiper_out #(.NUM_CH(NUM_CH), .DW(DW)) u_wout (
        .pos  (st_q.wiper),
        .halt (!st_q.run),
        .bus  (wiper_out)
    );

    logic [DW-1:0] ctrl_byte;
    logic [DW-1:0] rd_byte;
    logic [CW-1:0] ch_i, rc_i;
    logic [AW-1:0] g_off, r_off;

    always_comb begin
        ctrl_byte           = '0;
        ctrl_byte[MODE_BIT] = st_q.mode;
        ctrl_byte[RUN_BIT]  = st_q.run;
        ctrl_byte[BUSY_BIT] = nv_busy;
        ctrl_byte[ODT_BIT]  = st_q.odt;
    end

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        st_d.nvw_v = 1'b0;
        rd_byte    = '0;
        ch_i       = dec_addr[CW-1:0];
        g_off      = dec_addr - AW'(NUM_CH);
        rc_i       = recall_addr[CW-1:0];
        r_off      = recall_addr - AW'(NUM_CH);

        if (recall_valid) begin
            if (recall_addr < AW'(NUM_CH)) begin
                st_d.stored[rc_i] = recall_data;
                st_d.wiper[rc_i]  = recall_data;
            end else if (recall_addr < GP_END) begin
                st_d.gp[r_off[GW-1:0]] = recall_data;
            end
        end

        if (cmd_valid && (dec_rd || dec_wr)) begin
            if (!dec_blk) begin
                case (dec_kind)
                    K_CHAN: begin
                        if (st_q.mode) begin
                            rd_byte = st_q.wiper[ch_i];
                            if (dec_wr) st_d.wiper[ch_i] = wdata;
                        end else begin
                            rd_byte = st_q.stored[ch_i];
                            if (dec_wr) begin
                                st_d.stored[ch_i] = wdata;
                                st_d.wiper[ch_i]  = wdata;
                                st_d.nvw_v = 1'b1;
                                st_d.nvw_a = dec_addr;
                                st_d.nvw_d = wdata;
                            end
                        end
                    end
                    K_GP: begin
                        if (!st_q.mode) begin
                            rd_byte = st_q.gp[g_off[GW-1:0]];
                            if (dec_wr) begin
                                st_d.gp[g_off[GW-1:0]] = wdata;
                                st_d.nvw_v = 1'b1;
                                st_d.nvw_a = dec_addr;
                                st_d.nvw_d = wdata;
                            end
                        end
                    end
                    K_CTRL: begin
                        rd_byte = ctrl_byte;
                        if (dec_wr) begin
                            st_d.mode = wdata[MODE_BIT];
                            st_d.run  = wdata[RUN_BIT];
                            st_d.odt  = wdata[ODT_BIT];
                        end
                    end
                    default: ;
                endcase
            end
            if (dec_rd) begin
                st_d.rsp_v = 1'b1;
                st_d.rsp_w = {instr, rd_byte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.wiper  <= {NUM_CH{DW'(RESET_POS)}};
            st_q.stored <= {NUM_CH{DW'(RESET_POS)}};
            st_q.run    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shutdown       = !st_q.run;
    assign sdo_open_drain = st_q.odt;
    assign rsp_valid      = st_q.rsp_v;
    assign rsp_word       = st_q.rsp_w;
    assign nvw_valid      = st_q.nvw_v;
    assign nvw_addr       = st_q.nvw_a;
    assign nvw_data       = st_q.nvw_d;
endmodule

// File: rtl/potreg_exec_chk.sv
module potreg_exec_chk #(
    parameter int AW     = 5,
    parameter int DW     = 8,
    parameter int NUM_CH = 4,
    parameter int NUM_GP = 11,
    localparam int IW    = 3 + AW
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [IW-1:0]        cmd_instr,
    input logic                 nv_busy,
    input logic                 recall_valid,
    input logic [NUM_CH*DW-1:0] wiper_out,
    input logic                 shutdown,
    input logic                 rsp_valid,
    input logic [IW+DW-1:0]     rsp_word,
    input logic                 nvw_valid
);
    localparam logic [AW-1:0] CTRL_ADR = AW'(NUM_CH + NUM_GP + 1);

    // R1: a response echoes the instruction given one cycle earlier
    p_rsp_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid) && rsp_word[IW+DW-1:DW] == $past(cmd_instr));

    // R1: only read opcodes produce a response
    p_rsp_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_word[IW+DW-1:IW+DW-3] == 3'b001 ||
                       rsp_word[IW+DW-1:IW+DW-3] == 3'b100));

    // R8: shutdown forces every wiper output to zero
    p_shdn_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> wiper_out == '0);

    // R9: a busy cycle without recall moves no wiper and no run state
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && !recall_valid) |=> $stable(wiper_out) && $stable(shutdown));

    // R9: no write request comes out of a busy cycle
    p_busy_no_nvw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nvw_valid |-> $past(cmd_valid && !nv_busy));

    // R9: a blocked addressed read returns zero data
    p_blocked_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(nv_busy) && rsp_word[IW+DW-1:IW+DW-3] == 3'b100 &&
         rsp_word[DW+AW-1:DW] != CTRL_ADR) |-> rsp_word[DW-1:0] == '0);
endmodule

bind potreg_exec potreg_exec_chk #(.AW(AW), .DW(DW), .NUM_CH(NUM_CH), .NUM_GP(NUM_GP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_instr    (cmd_word[RW-1:DW]),
    .nv_busy      (nv_busy),
    .recall_valid (recall_valid),
    .wiper_out    (wiper_out),
    .shutdown     (shutdown),
    .rsp_valid    (rsp_valid),
    .rsp_word     (rsp_word),
    .nvw_valid    (nvw_valid)
);

// File: tb/potreg_exec_tb.sv
module potreg_exec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        nv_busy = 1'b0;
    logic        recall_valid = 1'b0;
    logic [4:0]  recall_addr = '0;
    logic [7:0]  recall_data = '0;
    logic [31:0] wiper_out;
    logic        shutdown, sdo_open_drain, rsp_valid, nvw_valid;
    logic [15:0] rsp_word;
    logic [4:0]  nvw_addr;
    logic [7:0]  nvw_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic        s_rv, s_nv;
    logic [15:0] s_rw;
    logic [4:0]  s_na;
    logic [7:0]  s_nd;

    potreg_exec u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .nv_busy(nv_busy), .recall_valid(recall_valid), .recall_addr(recall_addr),
        .recall_data(recall_data), .wiper_out(wiper_out), .shutdown(shutdown),
        .sdo_open_drain(sdo_open_drain), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .nvw_valid(nvw_valid), .nvw_addr(nvw_addr), .nvw_data(nvw_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one command on a falling edge, capture outputs at the next falling edge
    task automatic send(input logic [7:0] ins, input logic [7:0] dat);
        cmd_word  = {ins, dat};
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        s_rv = rsp_valid; s_rw = rsp_word;
        s_nv = nvw_valid; s_na = nvw_addr; s_nd = nvw_data;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        send({3'b100, a}, 8'h00);
        v = s_rw[7:0];
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        send(8'h60, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R2 wipers", wiper_out, 32'h80808080);
        check("R2 shutdown", {31'd0, shutdown}, 0);
        check("R2 sdo type", {31'd0, sdo_open_drain}, 0);
        send(8'h20, 8'h00);
        check("R2 ctrl read", {15'd0, s_rv, s_rw}, {15'd0, 1'b1, 16'h2040});
        rd(5'h01, v); check("R2 stored pos", {24'd0, v}, 32'h80);
        rd(5'h09, v); check("R2 gp zero", {24'd0, v}, 32'h00);
    endtask

    task automatic t_nop;
        logic [7:0] ins [4] = '{8'h00, 8'h41, 8'hA2, 8'hE3};
        for (int i = 0; i < 4; i++) begin
            send(ins[i], 8'h12);
            check("R1 no response", {31'd0, s_rv}, 0);
            check("R1 no request", {31'd0, s_nv}, 0);
        end
        check("R1 wipers unchanged", wiper_out, 32'h80808080);
        send(8'h20, 8'h00);
        check("R1 ctrl unchanged", {16'd0, s_rw}, 32'h2040);
    endtask

    task automatic t_ctrl;
        send(8'h7F, 8'hFF);
        check("R7 sdo type", {31'd0, sdo_open_drain}, 1);
        send(8'h25, 8'h00);
        check("R7 ctrl read ignores addr", {16'd0, s_rw}, 32'h25C2);
        rd(5'h10, s_nd);
        check("R7 ctrl via 10h", {24'd0, s_rw[7:0]}, 32'hC2);
        send(8'hD0, 8'h40);
        check("R7 ctrl write via 10h", {31'd0, sdo_open_drain}, 0);
        send(8'h20, 8'h00);
        check("R7 ctrl after write", {24'd0, s_rw[7:0]}, 32'h40);
    endtask

    task automatic t_chan;
        logic [7:0] v;
        send(8'hC2, 8'h5A);
        check("R4 nv request", {22'd0, s_nv, s_na, s_nd}, {22'd0, 1'b1, 5'h02, 8'h5A});
        check("R4 wiper loaded", {24'd0, wiper_out[23:16]}, 32'h5A);
        set_ctrl(8'hC0);
        send(8'hC2, 8'h11);
        check("R3 no request", {31'd0, s_nv}, 0);
        check("R3 wiper written", {24'd0, wiper_out[23:16]}, 32'h11);
        rd(5'h02, v); check("R3 wiper read", {24'd0, v}, 32'h11);
        set_ctrl(8'h40);
        rd(5'h02, v); check("R4 stored read", {24'd0, v}, 32'h5A);
        check("R4 read leaves wiper", {24'd0, wiper_out[23:16]}, 32'h11);
    endtask

    task automatic t_gp;
        logic [7:0] v;
        send(8'hCE, 8'h77);
        check("R5 gp request", {22'd0, s_nv, s_na, s_nd}, {22'd0, 1'b1, 5'h0E, 8'h77});
        rd(5'h0E, v); check("R5 gp read", {24'd0, v}, 32'h77);
        set_ctrl(8'hC0);
        rd(5'h0E, v); check("R5 gp hidden", {24'd0, v}, 32'h00);
        send(8'hCE, 8'h99);
        check("R5 gp write ignored no request", {31'd0, s_nv}, 0);
        set_ctrl(8'h40);
        rd(5'h0E, v); check("R5 gp kept", {24'd0, v}, 32'h77);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        send(8'hCF, 8'h33);
        check("R6 reserved no request", {31'd0, s_nv}, 0);
        rd(5'h0F, v); check("R6 reserved reads 0", {24'd0, v}, 32'h00);
        send(8'hDF, 8'h44);
        check("R6 high addr no request", {31'd0, s_nv}, 0);
        rd(5'h1F, v); check("R6 high addr read", {16'd0, s_rw}, 32'h9F00);
    endtask

    task automatic t_shutdown;
        set_ctrl(8'hC0);
        send(8'hC0, 8'h01); send(8'hC1, 8'h02); send(8'hC2, 8'h04); send(8'hC3, 8'hFE);
        check("R8 positions set", wiper_out, 32'hFE040201);
        set_ctrl(8'h80);
        check("R8 shutdown on", {31'd0, shutdown}, 1);
        check("R8 outputs zero", wiper_out, 0);
        send(8'hC1, 8'h33);
        check("R8 write hidden in shutdown", wiper_out, 0);
        set_ctrl(8'hC0);
        check("R8 restored", wiper_out, 32'hFE043301);
        check("R8 shutdown off", {31'd0, shutdown}, 0);
    endtask

    task automatic t_busy;
        logic [7:0] v;
        nv_busy = 1'b1;
        send(8'h20, 8'h00);
        check("R9 ctrl poll shows busy", {24'd0, s_rw[7:0]}, 32'hE0);
        rd(5'h00, v);
        check("R9 blocked read", {15'd0, s_rv, s_rw}, {15'd0, 1'b1, 16'h8000});
        send(8'hC0, 8'h55);
        check("R9 wiper write blocked", wiper_out, 32'hFE043301);
        send(8'h60, 8'h00);
        check("R9 ctrl write blocked", {31'd0, shutdown}, 0);
        rd(5'h10, v); check("R9 addressed ctrl poll", {24'd0, v}, 32'hE0);
        set_ctrl(8'h40);
        send(8'hC5, 8'h21);
        check("R9 no request while busy", {31'd0, s_nv}, 0);
        nv_busy = 1'b0;
        send(8'h20, 8'h00);
        check("R9 mode unchanged", {24'd0, s_rw[7:0]}, 32'hC0);
        rd(5'h00, v); check("R9 wiper kept", {24'd0, v}, 32'h01);
    endtask

    task automatic t_recall;
        logic [7:0] v;
        set_ctrl(8'h40);
        recall_valid = 1'b1; recall_addr = 5'h03; recall_data = 8'h3C;
        @(negedge clk);
        recall_addr = 5'h05; recall_data = 8'h66;
        @(negedge clk);
        recall_valid = 1'b0;
        check("R10 wiper recalled", {24'd0, wiper_out[31:24]}, 32'h3C);
        rd(5'h03, v); check("R10 stored recalled", {24'd0, v}, 32'h3C);
        rd(5'h05, v); check("R10 gp recalled", {24'd0, v}, 32'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nop();
        t_ctrl();
        t_chan();
        t_gp();
        t_reserved();
        t_shutdown();
        t_busy();
        t_recall();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule